// File: doc/BRIEF.md
# Board Interrupt Aggregator with Card-Slot Status

This block collects sixteen external interrupt inputs into a sticky status register and gates that register with an enable mask. It drives a single combined interrupt line towards the host processor. Software reaches it over a simple synchronous register bus with address, write enable, write data, read enable and read data. Read data returns one clock after the read request.

Two card-slot registers carry power and reset control bits that software can write, a fixed ready flag, and an active-low card-present flag. That flag tracks interrupt input 9 for the first slot and input 13 for the second. Eight further offsets are plain 32-bit storage for LED, switch and miscellaneous board settings. Every other offset reads as zero and ignores writes.

The raw input levels pass through a register every clock. All latching and card-detect tracking works from that registered copy. Software cannot read the registered copy.

Top module: `brd_irq_ctrl`

## Requirements
- R1: After reset, the mask (offset 0xC0) and status (offset 0xD0) registers read 0, irq_out is 0, bus_rdata is 0, and both slot registers (0xE0, 0xE4) read 0x0000_0420.
- R2: An input held high is captured into a level register at one edge. At the next edge, if its mask bit is set, the matching status bit sets. The status bit stays set after the input falls.
- R3: An input held high while its mask bit is 0 leaves its status bit at 0.
- R4: irq_out is a registered output that equals the OR of (status AND mask). It changes at the same clock edge as the register write or latch that alters either operand.
- R5: Mask and status are 20 bits wide. A write to either stores the low bits of the written value ANDed with 0xFEEFF, so bits 8 and 12 always read 0. A status write replaces the whole register, so set bits can be cleared and clear bits can be set.
- R6: Bit 5 of the slot register at 0xE0 reads as the inverse of the registered level of input 9. Bit 5 of the slot register at 0xE4 reads as the inverse of the registered level of input 13.
- R7: A write to a slot register changes only bits [4:0]. Bit 10 (ready) always reads 1, and bits 6 to 9 and 11 to 31 always read 0.
- R8: Offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each store a full 32-bit word and return it on read. Reset does not initialise them.
- R9: With the full address width decoded, a read from any other address (for example 0x44, or 0x100E0) returns 0. A write to such an address changes no register.
- R10: When an input would latch a status bit at the same edge as a software write to the status register, the written value wins.
- R11: bus_rdata carries the value selected by a read request in the cycle after it, and reads 0 in a cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IRQ (16) | External interrupt inputs, active high |
| bus_addr | input | ADDR_W (20) | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW (32) | Write data |
| bus_ren | input | 1 | Read request |
| bus_rdata | output | DW (32) | Read data, valid the cycle after bus_ren |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
The hardest case to reach is the collision in R10. In that case a masked input reaches the latch in the exact cycle that software overwrites the status register. If the input stayed high, it would simply latch again one edge later and hide the outcome. The stimulus therefore raises the input for exactly one clock, so the registered level is high only across the edge that carries the status write. It then reads status back and checks that the write won. The card-detect bits are also timed against the registered level: reads are issued one edge after each input change, so that the one-cycle sampling delay is exercised.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STAT,
    SEL_SLOT,
    SEL_SCR
  } reg_sel_e;

  localparam int OFF_MASK  = 'hC0;
  localparam int OFF_STAT  = 'hD0;
  localparam int OFF_SLOT0 = 'hE0;
  localparam int OFF_SLOT1 = 'hE4;
  localparam int N_SCR     = 8;

  // byte offset of scratch word i
  function automatic int scr_off(input int i);
    case (i)
      0:       return 'h10;
      1:       return 'h14;
      2:       return 'h40;
      3:       return 'h60;
      4:       return 'h80;
      5:       return 'h84;
      6:       return 'h88;
      default: return 'h90;
    endcase
  endfunction

endpackage

// File: rtl/brd_irq_decode.sv
module brd_irq_decode
  import brd_irq_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int SCR_IW = $clog2(N_SCR)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              slot_idx,
  output logic [SCR_IW-1:0] scr_idx
);

  logic [N_SCR-1:0] scr_hit;

  for (genvar g = 0; g < N_SCR; g++) begin : g_scr_hit
    assign scr_hit[g] = (addr == ADDR_W'(scr_off(g)));
  end

  always_comb begin
    scr_idx = '0;
    for (int i = 0; i < N_SCR; i++) begin
      if (scr_hit[i]) scr_idx = SCR_IW'(i);
    end
  end

  always_comb begin
    slot_idx = 1'b0;
    if (addr == ADDR_W'(OFF_MASK))       sel = SEL_MASK;
    else if (addr == ADDR_W'(OFF_STAT))  sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_SLOT0)) sel = SEL_SLOT;
    else if (addr == ADDR_W'(OFF_SLOT1)) begin
      sel      = SEL_SLOT;
      slot_idx = 1'b1;
    end
    else if (|scr_hit)                   sel = SEL_SCR;
    else                                 sel = SEL_NONE;
  end

endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core #(
  parameter int          N_IRQ    = 16,
  parameter int          REG_W    = 20,
  parameter logic [REG_W-1:0] WR_ALLOW = 20'hFEEFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             wr_mask,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  output logic [N_IRQ-1:0] lvl_q,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] stat_q,
  output logic             irq_q
);

  logic [REG_W-1:0] lvl_ext;
  logic [REG_W-1:0] mask_d;
  logic [REG_W-1:0] stat_d;

  assign lvl_ext = REG_W'(lvl_q);

  always_comb begin
    mask_d = wr_mask ? (wdata & WR_ALLOW) : mask_q;
    // a software write replaces the register and overrides any latch
    stat_d = wr_stat ? (wdata & WR_ALLOW) : (stat_q | (lvl_ext & mask_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      lvl_q  <= irq_in;
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_q  <= |(stat_d & mask_d);
    end
  end

endmodule

// File: rtl/brd_slot_reg.sv
module brd_slot_reg #(
  parameter int DW      = 32,
  parameter int CTL_W   = 5,
  parameter int CD_BIT  = 5,
  parameter int RDY_BIT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             cd_lvl,
  output logic [DW-1:0]    rd_val
);

  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctl_q <= '0;
    else if (wr) ctl_q <= wdata;
  end

  always_comb begin
    rd_val              = '0;
    rd_val[CTL_W-1:0]   = ctl_q;
    rd_val[CD_BIT]      = ~cd_lvl;
    rd_val[RDY_BIT]     = 1'b1;
  end

endmodule

// File: rtl/brd_scratch_bank.sv
module brd_scratch_bank #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[wr_idx] <= wdata;
    rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/brd_irq_ctrl.sv
module brd_irq_ctrl
  import brd_irq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DW     = 32,
  parameter int N_IRQ  = 16,
  parameter int REG_W  = 20,
  parameter int CD_IRQ0 = 9,
  parameter int CD_IRQ1 = 13,
  parameter int CTL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_ren,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_out
);

  localparam int SCR_IW = $clog2(N_SCR);

  reg_sel_e          sel;
  reg_sel_e          sel_q;
  logic              slot_idx;
  logic [SCR_IW-1:0] scr_idx;
  logic              wr_mask;
  logic              wr_stat;
  logic [N_IRQ-1:0]  lvl_q;
  logic [REG_W-1:0]  mask_q;
  logic [REG_W-1:0]  stat_q;
  logic [DW-1:0]     slot_rd [2];
  logic [DW-1:0]     scr_q;
  logic [DW-1:0]     rd_mux;
  logic [DW-1:0]     oth_q;

  brd_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .sel      (sel),
    .slot_idx (slot_idx),
    .scr_idx  (scr_idx)
  );

  assign wr_mask = bus_wen && (sel == SEL_MASK);
  assign wr_stat = bus_wen && (sel == SEL_STAT);

  brd_irq_core #(.N_IRQ(N_IRQ), .REG_W(REG_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .wr_mask (wr_mask),
    .wr_stat (wr_stat),
    .wdata   (bus_wdata[REG_W-1:0]),
    .lvl_q   (lvl_q),
    .mask_q  (mask_q),
    .stat_q  (stat_q),
    .irq_q   (irq_out)
  );

  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam int CDI = (g == 0) ? CD_IRQ0 : CD_IRQ1;
    brd_slot_reg #(.DW(DW), .CTL_W(CTL_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .wr     (bus_wen && (sel == SEL_SLOT) && (slot_idx == 1'(g))),
      .wdata  (bus_wdata[CTL_W-1:0]),
      .cd_lvl (lvl_q[CDI]),
      .rd_val (slot_rd[g])
    );
  end

  brd_scratch_bank #(.DEPTH(N_SCR), .DW(DW)) u_scr (
    .clk     (clk),
    .wr      (bus_wen && (sel == SEL_SCR)),
    .wr_idx  (scr_idx),
    .wdata   (bus_wdata),
    .rd_idx  (scr_idx),
    .rd_data (scr_q)
  );

  always_comb begin
    case (sel)
      SEL_MASK: rd_mux = DW'(mask_q);
      SEL_STAT: rd_mux = DW'(stat_q);
      SEL_SLOT: rd_mux = slot_rd[slot_idx];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_NONE;
      oth_q <= '0;
    end else begin
      sel_q <= bus_ren ? sel : SEL_NONE;
      oth_q <= bus_ren ? rd_mux : '0;
    end
  end

  assign bus_rdata = (sel_q == SEL_SCR) ? scr_q : oth_q;

endmodule

// File: rtl/brd_irq_chk.sv
module brd_irq_chk #(
  parameter int ADDR_W = 20,
  parameter int DW     = 32,
  parameter int N_IRQ  = 16,
  parameter int REG_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [REG_W-1:0]  wdata_lo,
  input logic              bus_ren,
  input logic [DW-1:0]     bus_rdata,
  input logic              irq_out,
  input logic [N_IRQ-1:0]  lvl,
  input logic [REG_W-1:0]  mask,
  input logic [REG_W-1:0]  stat
);

  localparam logic [REG_W-1:0] ALLOW = 20'hFEEFF;

  logic             wr_st;
  logic             wr_mk;
  logic [REG_W-1:0] lvl_x;

  assign wr_st = bus_wen && (bus_addr == ADDR_W'('hD0));
  assign wr_mk = bus_wen && (bus_addr == ADDR_W'('hC0));
  assign lvl_x = REG_W'(lvl);

  // R2: a masked high level sets its status bit at the next edge
  a_r2_latch: assert property (@(posedge clk) disable iff (rst)
    !wr_st |=> ((stat & $past(lvl_x & mask)) == $past(lvl_x & mask)));

  // R3: no bit rises where the mask was clear, unless software wrote it
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    !wr_st |=> ((stat & ~$past(stat) & ~$past(mask)) == '0));

  // R4: combined line tracks status AND mask
  a_r4_irq: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|(stat & mask)));

  // R5: mask writes are filtered
  a_r5_mask_wr: assert property (@(posedge clk) disable iff (rst)
    wr_mk |=> (mask == ($past(wdata_lo) & ALLOW)));

  // R6: first slot card-detect follows inverted input 9
  a_r6_cd0: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && bus_addr == ADDR_W'('hE0)) |=> (bus_rdata[5] == !$past(lvl[9])));

  // R7: ready flag is always set
  a_r7_ready: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && bus_addr == ADDR_W'('hE4)) |=> bus_rdata[10]);

  // R9: unmapped read returns zero
  a_r9_unmapped: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && bus_addr == ADDR_W'('h44)) |=> (bus_rdata == '0));

  // R10: software status write wins over a same-edge latch
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_st |=> (stat == ($past(wdata_lo) & ALLOW)));

endmodule

bind brd_irq_ctrl brd_irq_chk #(
  .ADDR_W (ADDR_W),
  .DW     (DW),
  .N_IRQ  (N_IRQ),
  .REG_W  (REG_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .wdata_lo  (bus_wdata[REG_W-1:0]),
  .bus_ren   (bus_ren),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .lvl       (lvl_q),
  .mask      (mask_q),
  .stat      (stat_q)
);

// File: tb/sim_brd_irq_ctrl.sv
`timescale 1ns/1ps
module sim_brd_irq_ctrl;

  localparam int ADDR_W = 20;
  localparam int DW     = 32;
  localparam int N_IRQ  = 16;
  localparam logic [ADDR_W-1:0] A_MASK  = 20'hC0;
  localparam logic [ADDR_W-1:0] A_STAT  = 20'hD0;
  localparam logic [ADDR_W-1:0] A_SLOT0 = 20'hE0;
  localparam logic [ADDR_W-1:0] A_SLOT1 = 20'hE4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N_IRQ-1:0]  irq_in = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wen = 1'b0;
  logic [DW-1:0]     bus_wdata = '0;
  logic              bus_ren = 1'b0;
  logic [DW-1:0]     bus_rdata;
  logic              irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_vld = 1'b0;

  logic [ADDR_W-1:0] scr_a [8] = '{20'h10, 20'h14, 20'h40, 20'h60,
                                    20'h80, 20'h84, 20'h88, 20'h90};

  always #2.5 clk = ~clk;

  brd_irq_ctrl u0 (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  function automatic void cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endfunction

  // monitor: one result per read request, in order
  always @(posedge clk) rd_vld <= bus_ren;

  always @(negedge clk) begin
    if (rd_vld) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R11: read data with no expected item, actual 0x%08h expected none",
                 bus_rdata);
      end else begin
        cmp(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    bus_ren  = 1'b1;
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_ren = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_wen   = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    cmp("R1 irq_out after reset", 32'(irq_out), 0);
    cmp("R11 idle rdata after reset", bus_rdata, 0);
    rd(A_MASK,  32'h0,   "R1 mask reset");
    rd(A_STAT,  32'h0,   "R1 status reset");
    rd(A_SLOT0, 32'h420, "R1 slot0 reset");
    rd(A_SLOT1, 32'h420, "R1 slot1 reset");

    // R8 scratch words
    for (int i = 0; i < 8; i++) wr(scr_a[i], 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
    for (int i = 0; i < 8; i++) rd(scr_a[i], 32'hA500_0000 ^ (32'(i) * 32'h0101_0101), "R8 scratch readback");

    // R9 unmapped addresses
    rd(20'h44,    32'h0, "R9 unmapped read 0x44");
    rd(20'h100E0, 32'h0, "R9 aliased read 0x100E0");
    wr(20'h44,    32'hFFFF_FFFF);
    wr(20'h100C0, 32'hFFFF_FFFF);
    wr(20'h10010, 32'h1234_5678);
    rd(A_MASK, 32'h0, "R9 aliased write left mask");
    rd(scr_a[0], 32'hA500_0000, "R9 aliased write left scratch");
    rd(scr_a[2], 32'hA500_0000 ^ 32'h0202_0202, "R9 unmapped write left scratch");

    // R5 write filtering
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h000F_EEFF, "R5 mask filtered");
    wr(A_STAT, 32'hFFFF_FFFF);
    cmp("R4 irq on after status write", 32'(irq_out), 1);
    rd(A_STAT, 32'h000F_EEFF, "R5 status filtered");
    wr(A_STAT, 32'h0);
    cmp("R4 irq off after status clear", 32'(irq_out), 0);
    wr(A_MASK, 32'h0);

    // R3 input with mask clear
    irq_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    cmp("R3 irq stays low", 32'(irq_out), 0);
    rd(A_STAT, 32'h0, "R3 status unchanged");
    irq_in[0] = 1'b0;

    // R2 latch path
    wr(A_MASK, 32'h3);
    irq_in[1] = 1'b1;
    @(negedge clk);
    cmp("R2 no latch one edge after input", 32'(irq_out), 0);
    @(negedge clk);
    cmp("R2 irq after latch", 32'(irq_out), 1);
    irq_in[1] = 1'b0;
    repeat (2) @(negedge clk);
    rd(A_STAT, 32'h2, "R2 status sticky after input drop");

    // R5 direct overwrite
    wr(A_STAT, 32'h1);
    rd(A_STAT, 32'h1, "R5 status replaced");
    cmp("R4 irq from written bit", 32'(irq_out), 1);
    wr(A_STAT, 32'h0);
    cmp("R4 irq cleared by overwrite", 32'(irq_out), 0);

    // R4 gating by mask
    wr(A_STAT, 32'h4);
    cmp("R4 unmasked status gives no irq", 32'(irq_out), 0);
    wr(A_MASK, 32'h7);
    cmp("R4 mask enable raises irq", 32'(irq_out), 1);
    wr(A_STAT, 32'h0);
    wr(A_MASK, 32'h0);

    // R6 card detect
    irq_in[9] = 1'b1;
    @(negedge clk);
    rd(A_SLOT0, 32'h400, "R6 slot0 card present");
    rd(A_SLOT1, 32'h420, "R6 slot1 unaffected");
    irq_in[13] = 1'b1;
    @(negedge clk);
    rd(A_SLOT1, 32'h400, "R6 slot1 card present");
    irq_in = '0;
    @(negedge clk);
    rd(A_SLOT0, 32'h420, "R6 slot0 card gone");
    rd(A_STAT, 32'h0, "R3 detect inputs left status");

    // R7 slot write restriction
    wr(A_SLOT0, 32'hFFFF_FFFF);
    rd(A_SLOT0, 32'h43F, "R7 slot0 low bits only");
    wr(A_SLOT1, 32'h0000_0015);
    rd(A_SLOT1, 32'h435, "R7 slot1 low bits only");
    irq_in[9] = 1'b1;
    @(negedge clk);
    rd(A_SLOT0, 32'h41F, "R7 control kept with card present");
    irq_in = '0;

    // R10 collision: one-cycle pulse meets a status write
    wr(A_MASK, 32'h8);
    irq_in[3] = 1'b1;
    @(negedge clk);
    irq_in[3] = 1'b0;
    wr(A_STAT, 32'h0);
    cmp("R10 irq low after write wins", 32'(irq_out), 0);
    rd(A_STAT, 32'h0, "R10 status holds written value");

    // R11 idle data
    repeat (2) @(negedge clk);
    cmp("R11 idle rdata", bus_rdata, 0);

    done = 1'b1;
    finish_run();
  end

endmodule